// File: doc/BRIEF.md
# Configurable Programmable-Array Output Cell

This cell sits behind one fixed OR group of a programmable AND array. It takes the group's four product terms and produces a pin value. A two-bit mode code selects the output behaviour: a plain active-high sum, an active-low sum, or an exclusive-OR of two partial sums, with an optional inverted form. A fourth code selects a registered output, in which the sum feeds a clocked D flip-flop.

A direction bit decides how the pin is used. With the bit clear, the cell drives the pin. With the bit set, the driver is released and the pin acts as an extra input. The cell always returns a true/complement literal pair to the array. In registered mode that pair carries the flip-flop state. Otherwise it carries the value seen on the pin. This lets one cell serve as a combinational output, a state variable, or a borrowed input. Four registered cells together can hold a machine of up to sixteen states.

Top module: `pal_out_cell`

## Requirements
- R1: With modeSel = 2'b00 and the pin driven, padOut equals the OR of terms[3:0].
- R2: With modeSel = 2'b01 and the pin driven, padOut equals the NOR of terms[3:0].
- R3: With modeSel = 2'b10, invXor = 0 and the pin driven, padOut equals (terms[0] OR terms[1]) XOR (terms[2] OR terms[3]).
- R4: With modeSel = 2'b10 and invXor = 1, padOut is the complement of the R3 value. In modes 2'b00 and 2'b01, invXor has no effect on padOut.
- R5: With modeSel = 2'b11, the internal flip-flop loads the OR of terms[3:0] at each rising clock edge, and padOut shows its state when driven. In any other mode, the flip-flop holds its value.
- R6: A high rst at a rising edge clears the flip-flop to 0. Reset takes priority over a load in the same edge and acts whatever the value of pinDir.
- R7: With pinDir = 1, padOe = 0 and padOut = 0. With pinDir = 0, padOe = 1.
- R8: Outside registered mode, fbTrue equals padIn when pinDir = 1 and equals the driven pin value when pinDir = 0. In every mode, fbComp is the complement of fbTrue.
- R9: In registered mode, fbTrue equals the flip-flop state whatever the value of pinDir. With pinDir = 1, the flip-flop keeps loading and padIn is not fed back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the flip-flop, active high |
| terms | input | 4 | Product terms of this OR group |
| modeSel | input | 2 | 00 sum, 01 inverted sum, 10 XOR of pairs, 11 registered |
| invXor | input | 1 | Selects the inverted form of the XOR mode |
| pinDir | input | 1 | 0 = drive the pin, 1 = release the pin as an input |
| padIn | input | 1 | Value present on the pin |
| padOut | output | 1 | Drive value of the pin (0 while released) |
| padOe | output | 1 | Drive enable of the pin |
| fbTrue | output | 1 | True literal returned to the array |
| fbComp | output | 1 | Complement literal returned to the array |

## Verification
Two functions can land in the same cycle: a flip-flop load and the release of the pin as an input. The bench sets pinDir high in registered mode while the terms change. It then checks that the enable and drive value go quiet, and that the feedback literals follow the newly loaded state rather than padIn. A second collision puts reset and a load with all terms high in one edge; this is judged by a zero state afterwards.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

  typedef enum logic [1:0] {
    MODE_OR  = 2'b00,
    MODE_NOR = 2'b01,
    MODE_XOR = 2'b10,
    MODE_REG = 2'b11
  } cellMode_t;

  typedef struct packed {
    logic capture;  // flip-flop loads this cycle
    logic useXor;   // pick the pair-XOR result
    logic useReg;   // pin and feedback come from the flip-flop
    logic invert;   // complement the combinational result
    logic drive;    // pin driver enabled
  } cellStrobe_t;

endpackage

// File: rtl/pal_cell_ctrl.sv
module pal_cell_ctrl
  import pal_cell_pkg::*;
(
  input  logic [1:0]  modeSel,
  input  logic        invXor,
  input  logic        pinDir,
  output cellStrobe_t strobes
);

  cellMode_t mode;

  always_comb begin
    mode            = cellMode_t'(modeSel);
    strobes         = '0;
    strobes.drive   = ~pinDir;
    unique case (mode)
      MODE_OR:  strobes.invert = 1'b0;
      MODE_NOR: strobes.invert = 1'b1;
      MODE_XOR: begin
        strobes.useXor = 1'b1;
        strobes.invert = invXor;
      end
      MODE_REG: begin
        strobes.capture = 1'b1;
        strobes.useReg  = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/pal_cell_dpath.sv
module pal_cell_dpath
  import pal_cell_pkg::*;
#(
  parameter int TERMS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TERMS-1:0] terms,
  input  cellStrobe_t      strobes,
  input  logic             padIn,
  output logic             padOut,
  output logic             fbTrue,
  output logic             fbComp
);

  localparam int GROUPS = 2;
  localparam int HALF   = TERMS / GROUPS;

  logic [GROUPS-1:0] groupOr;
  logic              sumAll;
  logic              pairXor;
  logic              combVal;
  logic              result;
  logic              stateQ;

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    assign groupOr[g] = |terms[g*HALF +: HALF];
  end

  assign sumAll  = |groupOr;
  assign pairXor = ^groupOr;
  assign combVal = (strobes.useXor ? pairXor : sumAll) ^ strobes.invert;
  assign result  = strobes.useReg ? stateQ : combVal;

  always_ff @(posedge clk) begin
    if (rst)                  stateQ <= 1'b0;
    else if (strobes.capture) stateQ <= sumAll;
  end

  assign padOut = strobes.drive ? result : 1'b0;
  assign fbTrue = strobes.useReg ? stateQ : (strobes.drive ? result : padIn);
  assign fbComp = ~fbTrue;

  // R5: a load cycle leaves the sum of that cycle in the flip-flop
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> (stateQ == $past(|terms)));

  // R5: outside registered mode the state is frozen
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> $stable(stateQ));

endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_cell_pkg::*;
#(
  parameter int TERMS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TERMS-1:0] terms,
  input  logic [1:0]       modeSel,
  input  logic             invXor,
  input  logic             pinDir,
  input  logic             padIn,
  output logic             padOut,
  output logic             padOe,
  output logic             fbTrue,
  output logic             fbComp
);

  cellStrobe_t strobes;

  pal_cell_ctrl u_ctrl (
    .modeSel (modeSel),
    .invXor  (invXor),
    .pinDir  (pinDir),
    .strobes (strobes)
  );

  pal_cell_dpath #(.TERMS(TERMS)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .terms   (terms),
    .strobes (strobes),
    .padIn   (padIn),
    .padOut  (padOut),
    .fbTrue  (fbTrue),
    .fbComp  (fbComp)
  );

  assign padOe = strobes.drive;

  // R7: a released pin neither drives nor shows a value
  a_r7_released_quiet: assert property (@(posedge clk) disable iff (rst)
    pinDir |-> (!padOe && !padOut));

  // R9: in registered mode with a driven pin, feedback matches the pin
  a_r9_state_fb: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'b11 && !pinDir) |-> (fbTrue == padOut));

endmodule

// File: tb/tb_pal_out_cell.sv
module tb_pal_out_cell;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] terms = 4'b1111;
  logic [1:0] modeSel = 2'b11;
  logic       invXor = 1'b0;
  logic       pinDir = 1'b0;
  logic       padIn = 1'b0;
  logic       padOut, padOe, fbTrue, fbComp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pal_out_cell dut (
    .clk(clk), .rst(rst), .terms(terms), .modeSel(modeSel),
    .invXor(invXor), .pinDir(pinDir), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbTrue(fbTrue), .fbComp(fbComp)
  );

  // {mode, invXor, terms, expected pin}
  localparam logic [7:0] VEC [15] = '{
    {2'b00, 1'b0, 4'b0000, 1'b0},
    {2'b00, 1'b0, 4'b0100, 1'b1},
    {2'b00, 1'b1, 4'b0000, 1'b0},
    {2'b01, 1'b0, 4'b0000, 1'b1},
    {2'b01, 1'b0, 4'b1000, 1'b0},
    {2'b01, 1'b1, 4'b0001, 1'b0},
    {2'b10, 1'b0, 4'b0000, 1'b0},
    {2'b10, 1'b0, 4'b0010, 1'b1},
    {2'b10, 1'b0, 4'b1000, 1'b1},
    {2'b10, 1'b0, 4'b0101, 1'b0},
    {2'b10, 1'b0, 4'b1111, 1'b0},
    {2'b10, 1'b1, 4'b0001, 1'b0},
    {2'b10, 1'b1, 4'b0000, 1'b1},
    {2'b10, 1'b1, 4'b1100, 1'b0},
    {2'b10, 1'b1, 4'b0110, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic afterEdge();
    @(posedge clk);
    #5;
  endtask

  initial begin
    // R6: reset and a load of all-ones in the same edge leave 0
    afterEdge();
    chk("R6 reset beats load", padOut, 1'b0);
    chk("R7 driven pin enabled", padOe, 1'b1);

    // R5: load
    @(negedge clk); rst = 1'b0; terms = 4'b0010;
    #5 chk("R5 no change before edge", padOut, 1'b0);
    afterEdge();
    chk("R5 loaded pin", padOut, 1'b1);
    chk("R9 state feedback", fbTrue, 1'b1);

    // R5: hold outside registered mode
    @(negedge clk); modeSel = 2'b00; terms = 4'b0000;
    afterEdge();
    chk("R1 sum zero", padOut, 1'b0);
    @(negedge clk); modeSel = 2'b11;
    #5 chk("R5 state held", padOut, 1'b1);
    afterEdge();
    chk("R5 reload zero", padOut, 1'b0);

    // combinational vectors
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      modeSel = VEC[i][7:6];
      invXor  = VEC[i][5];
      terms   = VEC[i][4:1];
      #5;
      case (VEC[i][7:6])
        2'b00:   chk("R1/R4 sum vector", padOut, VEC[i][0]);
        2'b01:   chk("R2/R4 inverted sum vector", padOut, VEC[i][0]);
        default: chk(VEC[i][5] ? "R4 xnor vector" : "R3 xor vector", padOut, VEC[i][0]);
      endcase
      chk("R8 driven feedback", fbTrue, VEC[i][0]);
      chk("R8 complement", fbComp, ~VEC[i][0]);
    end
    invXor = 1'b0;

    // R9: registered with released pin
    @(negedge clk); modeSel = 2'b11; pinDir = 1'b1; padIn = 1'b1; terms = 4'b0001;
    #5;
    chk("R7 released enable", padOe, 1'b0);
    chk("R7 released value", padOut, 1'b0);
    chk("R9 state not pin", fbTrue, 1'b0);
    afterEdge();
    chk("R9 loads while released", fbTrue, 1'b1);
    @(negedge clk); terms = 4'b0000;
    afterEdge();
    chk("R9 ignores padIn", fbTrue, 1'b0);
    chk("R8 complement reg", fbComp, 1'b1);
    @(negedge clk); terms = 4'b1000;
    afterEdge();
    chk("R9 reload one", fbTrue, 1'b1);
    @(negedge clk); rst = 1'b1;
    afterEdge();
    chk("R6 reset while released", fbTrue, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R8: combinational mode with released pin
    @(negedge clk); modeSel = 2'b00; terms = 4'b1111; padIn = 1'b1;
    #5;
    chk("R8 pin fed back", fbTrue, 1'b1);
    chk("R8 pin complement", fbComp, 1'b0);
    chk("R7 released comb value", padOut, 1'b0);
    chk("R7 released comb enable", padOe, 1'b0);
    padIn = 1'b0;
    #1 chk("R8 pin low fed back", fbTrue, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule